// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex, 8-bit serial port with a shared transfer clock. Software configures it through a small register bus. Each frame shifts one byte out on the transmit pin and, on the same clock, shifts one byte in from the receive pin.

When it is the clock master, the block derives the transfer clock from the system clock. A prescaler divides the system clock by 1, 8 or 32, and a programmable divisor divides the result again. When it is the clock slave, it follows edges on an external clock input. One register bit selects which clock edge launches transmit data and which edge samples receive data. Another bit selects LSB-first or MSB-first shifting.

Writing the transmit register starts a frame. If a frame is already in progress, the written byte waits in a holding register and goes out directly after the current frame. A status flag shows when the shift register is empty. A second flag shows that a received byte is waiting to be read.

Top module: `csio_top`

## Requirements
- R1: After reset the mode register (address 0) reads 0x00 and the control register (address 1) reads 0x08. Bit 3 of the control register is the read-only shift-empty flag, so `tx_empty` is 1 and `rx_full` is 0.
- R2: Transfers run only when mode bits [2:0] equal 001. With any other mode code, a write to the transmit register (address 3) leaves `tx_empty` at 1 and the clock pin quiet. Leaving mode 001 aborts a frame in progress.
- R3: With the internal clock (mode bit 3 = 0), `sclk_oe` is 1 while the block is enabled. Each half period of `sclk_o` lasts P*(D+1) system cycles. D is the divisor register (address 2). P is chosen by control bits [1:0]: 00 gives 1, 01 gives 8, 10 gives 32, and 11 gives 1.
- R4: A new value in control bits [1:0] takes effect only at the next write of the divisor register.
- R5: When control bit 6 is 0, the clock idles high, transmit data changes on falling edges and receive data is sampled on rising edges. When bit 6 is 1, all of this is inverted. A frame has exactly eight clock pulses and ends with the clock at its idle level.
- R6: When control bit 7 is 0, bit 0 is shifted first on both pins. When it is 1, bit 7 is shifted first.
- R7: `tx_empty` falls on a transmit-register write accepted in mode 001. It rises again once the last bit of the frame has been sampled.
- R8: The eight sampled receive bits form the byte read at address 4. `rx_full` is set when the eighth bit is sampled and is cleared by a read of address 4.
- R9: A transmit write made while a frame is in progress is held. It goes out as the next frame with no idle gap and no loss of data.
- R10: With mode bit 3 set to 1, `sclk_oe` is 0 and the frame advances on edges of `sclk_i`, using the same edge rules as R5.
- R11: Control bit 5 is stored, reads back, and drives `od_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 4 clears `rx_full`) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| sclk_i | input | 1 | External transfer clock |
| sclk_o | output | 1 | Generated transfer clock |
| sclk_oe | output | 1 | Drive enable for the clock pin |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |
| od_sel | output | 1 | Open-drain select for the transmit pad |
| tx_empty | output | 1 | Shift register empty |
| rx_full | output | 1 | Received byte waiting |

## Verification
The bench uses the default 8-bit register width and runs the divisor only at 0 to 2. This keeps every frame short enough to run all four count-source codes, both polarities and both bit orders within a few thousand cycles. Each of these short settings still yields a distinct half-period length for the bench to measure. A divisor of 0 makes the clock toggle on every prescaled tick, which puts the back-to-back holding path and the final-edge handoff under the tightest timing.

// File: rtl/csio_pkg.sv
package csio_pkg;

    localparam int unsigned FRAME_BITS = 8;
    localparam int unsigned PRE_W      = 6;

    localparam logic [2:0] ADDR_MODE = 3'd0;
    localparam logic [2:0] ADDR_CTRL = 3'd1;
    localparam logic [2:0] ADDR_DIV  = 3'd2;
    localparam logic [2:0] ADDR_TX   = 3'd3;
    localparam logic [2:0] ADDR_RX   = 3'd4;

    localparam logic [2:0] MODE_SYNC = 3'b001;

    typedef enum logic [1:0] {
        SRC_DIV1  = 2'b00,
        SRC_DIV8  = 2'b01,
        SRC_DIV32 = 2'b10,
        SRC_RSVD  = 2'b11
    } clk_src_e;

    typedef struct packed {
        logic     msb_first;
        logic     pol;
        logic     od;
        clk_src_e src;
    } ctrl_t;

    typedef struct packed {
        logic       clk_ext;
        logic [2:0] func;
    } mode_t;

    // prescale ratio minus one; the reserved code falls back to divide-by-1
    function automatic logic [PRE_W-1:0] pre_last(clk_src_e s);
        case (s)
            SRC_DIV8:  pre_last = PRE_W'(7);
            SRC_DIV32: pre_last = PRE_W'(31);
            default:   pre_last = '0;
        endcase
    endfunction

endpackage

// File: rtl/csio_regs.sv
module csio_regs
    import csio_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             tx_empty,
    input  logic [REG_W-1:0] rx_byte,
    input  logic             rx_done,
    output logic [REG_W-1:0] rdata,
    output mode_t            mode_q,
    output ctrl_t            ctrl_q,
    output logic [REG_W-1:0] div_q,
    output clk_src_e         src_eff,
    output logic             tx_wr,
    output logic             rx_full
);
    logic rx_rd;

    assign tx_wr = wr_en && (addr == ADDR_TX);
    assign rx_rd = rd_en && (addr == ADDR_RX);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            ctrl_q  <= '0;
            div_q   <= '0;
            src_eff <= SRC_DIV1;
            rx_full <= 1'b0;
        end else begin
            if (wr_en && addr == ADDR_MODE)
                mode_q <= '{clk_ext: wdata[3], func: wdata[2:0]};
            if (wr_en && addr == ADDR_CTRL)
                ctrl_q <= '{msb_first: wdata[7], pol: wdata[6], od: wdata[5],
                            src: clk_src_e'(wdata[1:0])};
            if (wr_en && addr == ADDR_DIV) begin
                div_q   <= wdata;
                src_eff <= ctrl_q.src;
            end
            if (rx_done)
                rx_full <= 1'b1;
            else if (rx_rd)
                rx_full <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_MODE: rdata[3:0] = {mode_q.clk_ext, mode_q.func};
            ADDR_CTRL: rdata = REG_W'({ctrl_q.msb_first, ctrl_q.pol, ctrl_q.od,
                                       1'b0, tx_empty, 1'b0, ctrl_q.src});
            ADDR_DIV:  rdata = div_q;
            ADDR_RX:   rdata = rx_byte;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/csio_baud.sv
module csio_baud
    import csio_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  clk_src_e         src,
    input  logic [DIV_W-1:0] div,
    output logic             half
);
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [PRE_W-1:0] pre_lim;
    logic             tick;

    assign pre_lim = pre_last(src);
    assign tick    = run && (pre_cnt == pre_lim);
    assign half    = tick && (div_cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
            div_cnt <= (div_cnt == div) ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/csio_shifter.sv
module csio_shifter
    import csio_pkg::*;
#(
    parameter int unsigned W = FRAME_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         clk_ext,
    input  logic         pol,
    input  logic         msb_first,
    input  logic         start,
    input  logic [W-1:0] start_data,
    input  logic         half,
    input  logic         sclk_i,
    input  logic         rxd_i,
    output logic         busy,
    output logic         txd,
    output logic         sclk_int,
    output logic [W-1:0] rx_data,
    output logic         frame_end
);
    localparam int unsigned CNT_W = $clog2(W);

    logic [W-1:0]     tx_sr, rx_sr, hold_data, rx_next;
    logic             hold_full;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       sync;
    logic             ext_fall, ext_rise, launch, sample;

    assign ext_fall  = sync[2] && !sync[1];
    assign ext_rise  = !sync[2] && sync[1];
    assign launch    = busy && (clk_ext ? (pol ? ext_rise : ext_fall)
                                        : (half && sclk_int == !pol));
    assign sample    = busy && (clk_ext ? (pol ? ext_fall : ext_rise)
                                        : (half && sclk_int == pol));
    assign rx_next   = msb_first ? {rx_sr[W-2:0], rxd_i} : {rxd_i, rx_sr[W-1:1]};
    assign frame_end = sample && (cnt == CNT_W'(W-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            hold_full <= 1'b0;
            hold_data <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            rx_data   <= '0;
            cnt       <= '0;
            txd       <= 1'b1;
            sclk_int  <= 1'b1;
            sync      <= 3'b111;
        end else begin
            sync <= {sync[1:0], sclk_i};
            if (!enable) begin
                busy      <= 1'b0;
                hold_full <= 1'b0;
                sclk_int  <= !pol;
            end else begin
                if (!busy)
                    sclk_int <= !pol;
                else if (half && !clk_ext)
                    sclk_int <= !sclk_int;

                if (start && !busy) begin
                    tx_sr <= start_data;
                    busy  <= 1'b1;
                    cnt   <= '0;
                end else if (start && !(frame_end && !hold_full)) begin
                    hold_data <= start_data;
                    hold_full <= 1'b1;
                end

                if (launch) begin
                    txd   <= msb_first ? tx_sr[W-1] : tx_sr[0];
                    tx_sr <= msb_first ? {tx_sr[W-2:0], 1'b0} : {1'b0, tx_sr[W-1:1]};
                end

                if (sample) begin
                    rx_sr <= rx_next;
                    if (frame_end) begin
                        rx_data <= rx_next;
                        cnt     <= '0;
                        if (hold_full) begin
                            tx_sr     <= hold_data;
                            hold_full <= start;
                        end else if (start) begin
                            tx_sr <= start_data;
                        end else begin
                            busy <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/csio_top.sv
module csio_top
    import csio_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             sclk_i,
    output logic             sclk_o,
    output logic             sclk_oe,
    output logic             txd_o,
    input  logic             rxd_i,
    output logic             od_sel,
    output logic             tx_empty,
    output logic             rx_full
);
    mode_t             mode_q;
    ctrl_t             ctrl_q;
    clk_src_e          src_eff;
    logic [REG_W-1:0]  div_q;
    logic [FRAME_BITS-1:0] rx_data;
    logic              tx_wr, busy, half, frame_end, enabled, pol_w;

    assign enabled  = (mode_q.func == MODE_SYNC);
    assign pol_w    = ctrl_q.pol;
    assign tx_empty = !busy;
    assign sclk_oe  = enabled && !mode_q.clk_ext;
    assign od_sel   = ctrl_q.od;

    csio_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .tx_empty(tx_empty), .rx_byte(REG_W'(rx_data)),
        .rx_done(frame_end), .rdata(rdata), .mode_q(mode_q), .ctrl_q(ctrl_q),
        .div_q(div_q), .src_eff(src_eff), .tx_wr(tx_wr), .rx_full(rx_full)
    );

    csio_baud #(.DIV_W(REG_W)) u_baud (
        .clk(clk), .rst(rst), .run(busy && !mode_q.clk_ext),
        .src(src_eff), .div(div_q), .half(half)
    );

    csio_shifter #(.W(FRAME_BITS)) u_shift (
        .clk(clk), .rst(rst), .enable(enabled), .clk_ext(mode_q.clk_ext),
        .pol(ctrl_q.pol), .msb_first(ctrl_q.msb_first), .start(tx_wr),
        .start_data(wdata[FRAME_BITS-1:0]), .half(half), .sclk_i(sclk_i),
        .rxd_i(rxd_i), .busy(busy), .txd(txd_o), .sclk_int(sclk_o),
        .rx_data(rx_data), .frame_end(frame_end)
    );
endmodule

// File: rtl/csio_chk.sv
module csio_chk
    import csio_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [2:0] addr,
    input logic       tx_empty,
    input logic       rx_full,
    input logic       sclk_o,
    input logic       pol,
    input logic       enabled
);
    // R7
    tx_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_empty) |-> $past(wr_en && addr == ADDR_TX));

    // R8
    rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_full) |-> $past(rd_en && addr == ADDR_RX));

    // R8
    rx_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(!tx_empty));

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && $stable(pol)) |-> (sclk_o == !pol));

    // R2
    disabled_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!enabled) |-> tx_empty);
endmodule

bind csio_top csio_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .tx_empty(tx_empty), .rx_full(rx_full), .sclk_o(sclk_o),
    .pol(pol_w), .enabled(enabled)
);

// File: tb/sim_csio_top.sv
module sim_csio_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sclk_i = 1'b1, sclk_o, sclk_oe, txd_o, rxd_i = 1'b1, od_sel;
    logic       tx_empty, rx_full;

    int n_chk = 0, n_bad = 0;

    always #2 clk = !clk;

    csio_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sclk_i(sclk_i), .sclk_o(sclk_o),
        .sclk_oe(sclk_oe), .txd_o(txd_o), .rxd_i(rxd_i), .od_sel(od_sel),
        .tx_empty(tx_empty), .rx_full(rx_full)
    );

    // {src[27:26], div[25:18], pol[17], msb[16], tx[15:8], rx[7:0]}
    localparam logic [27:0] VEC [6] = '{
        {2'd0, 8'd0, 1'b0, 1'b0, 8'hA5, 8'h3C},
        {2'd0, 8'd2, 1'b1, 1'b0, 8'h96, 8'hE1},
        {2'd1, 8'd1, 1'b0, 1'b1, 8'h4B, 8'hD2},
        {2'd2, 8'd0, 1'b1, 1'b1, 8'hC3, 8'h18},
        {2'd3, 8'd1, 1'b0, 1'b0, 8'h7E, 8'h81},
        {2'd1, 8'd0, 1'b1, 1'b0, 8'h01, 8'h80}
    };

    // slave model for internal-clock frames
    logic       m_on = 1'b0, m_pol = 1'b0, m_msb = 1'b0, m_prev = 1'b1;
    logic [7:0] m_rx = '0, m_cur = '0;
    logic [7:0] m_cap [4];
    int         m_idx = 0, m_frames = 0, m_gap = 0, m_cnt = 0;

    always @(negedge clk) begin
        if (m_on) begin
            m_cnt = m_cnt + 1;
            if (sclk_o != m_prev) begin
                m_gap = m_cnt;
                m_cnt = 0;
                if (sclk_o != !m_pol) begin
                    rxd_i = m_rx[m_msb ? 7 - m_idx : m_idx];
                end else begin
                    m_cur[m_msb ? 7 - m_idx : m_idx] = txd_o;
                    m_idx = m_idx + 1;
                    if (m_idx == 8) begin
                        if (m_frames < 4) m_cap[m_frames] = m_cur;
                        m_frames = m_frames + 1;
                        m_idx = 0;
                    end
                end
            end
            m_prev = sclk_o;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (!tx_empty && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic model_arm(input logic pol, input logic msb, input logic [7:0] rxb);
        m_pol = pol; m_msb = msb; m_rx = rxb;
        m_idx = 0; m_frames = 0; m_cnt = 0; m_gap = 0;
        @(negedge clk);
        m_prev = sclk_o;
        m_on = 1'b1;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, r); check("R1 mode reset", r, 8'h00);
        rd(3'd1, r); check("R1 ctrl reset", r, 8'h08);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rx_full", rx_full, 0);
        wr(3'd1, 8'h00); rd(3'd1, r);
        check("R1 empty flag read-only", r, 8'h08);

        // R2 disabled and illegal modes
        wr(3'd0, 8'h00); wr(3'd3, 8'h55);
        repeat (3) @(negedge clk);
        check("R2 mode 000 ignores tx", tx_empty, 1);
        wr(3'd0, 8'h04); wr(3'd3, 8'h55);
        repeat (20) @(negedge clk);
        check("R2 mode 100 ignores tx", tx_empty, 1);
        check("R2 clock idle", sclk_o, 1);
        check("R2 no clock drive", sclk_oe, 0);

        // R3 R5 R6 R7 R8 vector table
        for (int i = 0; i < 6; i++) begin
            logic [1:0] src; logic [7:0] dv; logic pl, mb; logic [7:0] txb, rxb;
            int pre;
            {src, dv, pl, mb, txb, rxb} = VEC[i];
            pre = (src == 2'd1) ? 8 : (src == 2'd2) ? 32 : 1;
            wr(3'd1, {mb, pl, 4'b0000, src});
            wr(3'd2, dv);
            wr(3'd0, 8'h01);
            check("R3 clock driven", sclk_oe, 1);
            model_arm(pl, mb, rxb);
            wr(3'd3, txb);
            check("R7 busy after write", tx_empty, 0);
            wait_idle();
            repeat (2) @(negedge clk);
            m_on = 1'b0;
            check("R7 empty after frame", tx_empty, 1);
            check("R5 eight pulses", m_frames, 1);
            check("R6 tx order", m_cap[0], txb);
            check("R3 half period", m_gap, pre * (dv + 1));
            check("R5 idle level", sclk_o, !pl);
            check("R8 rx_full set", rx_full, 1);
            rd(3'd4, r);
            check("R8 rx byte", r, rxb);
            check("R8 rx_full cleared", rx_full, 0);
        end

        // R4 count source waits for divisor write
        wr(3'd1, 8'h01); wr(3'd2, 8'h00);
        wr(3'd1, 8'h02);
        model_arm(1'b0, 1'b0, 8'h00);
        wr(3'd3, 8'h33); wait_idle(); repeat (2) @(negedge clk); m_on = 1'b0;
        check("R4 old source kept", m_gap, 8);
        wr(3'd2, 8'h00);
        model_arm(1'b0, 1'b0, 8'h00);
        wr(3'd3, 8'h33); wait_idle(); repeat (2) @(negedge clk); m_on = 1'b0;
        check("R4 new source after div write", m_gap, 32);
        rd(3'd4, r);

        // R9 back-to-back frames through the holding register
        wr(3'd1, 8'h00); wr(3'd2, 8'h01);
        model_arm(1'b0, 1'b0, 8'h6A);
        wr(3'd3, 8'hF0); wr(3'd3, 8'h0F);
        wait_idle(); repeat (2) @(negedge clk); m_on = 1'b0;
        check("R9 two frames", m_frames, 2);
        check("R9 first byte", m_cap[0], 8'hF0);
        check("R9 second byte", m_cap[1], 8'h0F);
        rd(3'd4, r);
        check("R9 rx byte", r, 8'h6A);

        // R10 external clock, pol 0, LSB first
        sclk_i = 1'b1;
        wr(3'd1, 8'h00); wr(3'd0, 8'h09);
        repeat (4) @(negedge clk);
        check("R10 clock not driven", sclk_oe, 0);
        begin
            logic [7:0] cap, rxb;
            rxb = 8'hB4;
            wr(3'd3, 8'h2D);
            for (int k = 0; k < 8; k++) begin
                sclk_i = 1'b0; rxd_i = rxb[k];
                repeat (8) @(negedge clk);
                cap[k] = txd_o;
                sclk_i = 1'b1;
                repeat (8) @(negedge clk);
            end
            repeat (4) @(negedge clk);
            check("R10 frame done", tx_empty, 1);
            check("R10 tx byte", cap, 8'h2D);
            rd(3'd4, r);
            check("R10 rx byte", r, rxb);
        end

        // R11 open-drain select
        wr(3'd1, 8'h20);
        rd(3'd1, r);
        check("R11 readback", r, 8'h28);
        check("R11 od_sel", od_sel, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule